// File: doc/BRIEF.md
# Master Clock Ratio Detector and Frame Sync Monitor

This block watches the frame clock (one period per stereo sample) as seen from the master clock domain. It counts master clock cycles between rising frame-clock edges and classifies the master clock as 256, 384 or 512 times the sample rate. From the accepted ratio it produces a clock enable that pulses at an effective 256x sample rate, so the filter and modulator logic downstream can run on one fixed rate whatever master clock the board supplies.

Once a ratio is accepted, the block keeps checking each frame against the nominal period. Phase jitter of the frame clock is allowed as long as it stays within four bit-clock periods. The size of one bit-clock period in master clocks is derived from the accepted ratio and the number of bit clocks per frame. A larger jump, or a frame edge that never arrives, drops synchronization. While it is dropped, the converter paths are told to mute: the capture path outputs zero and the playback path freezes on its last sample. The mute stays on for a fixed 32 frames after synchronization is regained.

The frame clock input must already be synchronized to the master clock.

Top module: `clk_ratio_monitor`

## Requirements
- R1: During and immediately after reset, `ratio` is 0 (none), `ce_256fs`, `sync_ok` are low and `adc_zero`, `dac_hold` are high.
- R2: A frame period is the number of master clock cycles between two successive rising edges of `lrck`. The first rising edge after reset only starts the count. A period within ±2 cycles of 256, 384 or 512 is classified as ratio code 1, 2 or 3 respectively. Any other length is classified as code 0 (none).
- R3: While unsynchronized, `sync_ok` rises and `ratio` takes the class code on the `lrck` edge that ends a second consecutive period of the same non-zero class. With default reset-to-steady stimulus, this is the third rising edge. Periods of different classes never lock, and `ratio` changes only at such a lock.
- R4: With ratio code 1, `ce_256fs` is high every cycle. With code 2, it is high on exactly 2 of every 3 consecutive cycles. With code 3, it alternates every cycle.
- R5: With ratio code 0, `ce_256fs` stays low.
- R6: While synchronized, a period that differs from the nominal length N by d cycles is ignored when d × `bck_per_frame` ≤ 4 × N. Otherwise synchronization is lost at that edge. Example: N=256 with 64 bit clocks allows 16 cycles, and N=512 with 32 bit clocks allows 64 cycles.
- R7: While synchronized, if no rising edge arrives, synchronization is lost as soon as the running count exceeds N by more than the R6 limit. This happens within one sample period of the missing edge.
- R8: While `sync_ok` is low, `adc_zero` and `dac_hold` are high, and `ratio` keeps its last accepted value.
- R9: After a lock, `adc_zero` and `dac_hold` stay high through 31 further rising edges and fall on the 32nd.
- R10: After a loss, the period that caused it does not count. Re-lock needs two fresh same-class periods and may settle on a different ratio than before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| lrck | input | 1 | Frame clock, already synchronized to `clk` |
| bck_per_frame | input | BPF_W | Bit clocks per frame (32, 48 or 64) |
| ratio | output | 2 | Accepted ratio: 0 none, 1 = 256x, 2 = 384x, 3 = 512x |
| ce_256fs | output | 1 | Clock enable at 256x the sample rate |
| sync_ok | output | 1 | Frame clock locked to the master clock |
| adc_zero | output | 1 | Force capture data to zero |
| dac_hold | output | 1 | Hold the last playback sample |

## Verification
Several properties are checked on every cycle: the enable patterns for each ratio, the silence of the enable with no ratio, the mute flags staying asserted whenever sync is low, `ratio` moving only together with a lock, and the mute release happening only while locked. The directed scenarios are the only way to show the rest. These are the exact edge on which lock and release occur, the boundary between an ignored and a fatal phase jump for two ratio and bit-clock combinations, the classification tolerance at ±2 and ±3 cycles, a stopped frame clock being caught before the next edge is due, and re-lock onto a different ratio.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;

    typedef enum logic [1:0] {
        RATIO_NONE = 2'd0,
        RATIO_256  = 2'd1,
        RATIO_384  = 2'd2,
        RATIO_512  = 2'd3
    } ratio_e;

    typedef enum logic {
        ST_ACQUIRE = 1'b0,
        ST_LOCKED  = 1'b1
    } sync_st_e;

    typedef struct packed {
        logic   locked;
        logic   running;
        ratio_e ratio;
    } mon_state_t;

    localparam int unsigned NUM_RATIOS = 3;
    localparam int unsigned BASE_LEN   = 128;

    // Nominal frame length in master clocks for a ratio code.
    function automatic int unsigned nominal_len(ratio_e r);
        return (r == RATIO_NONE) ? 0 : BASE_LEN * (int'(r) + 1);
    endfunction

    // Class of a measured period, NONE when no ratio lies within tol.
    function automatic ratio_e classify(int unsigned len, int unsigned tol);
        ratio_e res;
        res = RATIO_NONE;
        for (int i = 1; i <= int'(NUM_RATIOS); i++) begin
            logic [1:0]  code;
            int unsigned nom;
            code = 2'(i);
            nom  = nominal_len(ratio_e'(code));
            if ((len + tol >= nom) && (len <= nom + tol))
                res = ratio_e'(code);
        end
        return res;
    endfunction

    // dev/(nom/bpf) > steps, evaluated without a divider.
    function automatic logic beyond_limit(int unsigned dev, int unsigned nom,
                                          int unsigned bpf, int unsigned steps);
        return (dev * bpf) > (steps * nom);
    endfunction

endpackage

// File: rtl/clkmon_frame_meter.sv
module clkmon_frame_meter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lrck,
    output logic             edge_ok,
    output logic [CNT_W-1:0] count
);
    logic             lrck_q;
    logic             seen;
    logic [CNT_W-1:0] cnt;
    logic             rise;

    assign rise = lrck & ~lrck_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lrck_q <= 1'b0;
            seen   <= 1'b0;
            cnt    <= '0;
        end else begin
            lrck_q <= lrck;
            if (rise) begin
                seen <= 1'b1;
                cnt  <= CNT_W'(1);
            end else if (cnt != '1) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign edge_ok = rise & seen;
    assign count   = cnt;
endmodule

// File: rtl/clkmon_sync_fsm.sv
module clkmon_sync_fsm
    import clkmon_pkg::*;
#(
    parameter int CNT_W          = 12,
    parameter int BPF_W          = 8,
    parameter int TOL            = 2,
    parameter int SHIFT_BCK      = 4,
    parameter int RECOVER_FRAMES = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             edge_ok,
    input  logic [CNT_W-1:0] count,
    input  logic [BPF_W-1:0] bpf,
    output mon_state_t       mon
);
    localparam int REC_W = $clog2(RECOVER_FRAMES + 1);
    localparam logic [REC_W-1:0] REC_DONE = REC_W'(RECOVER_FRAMES);

    sync_st_e        st;
    ratio_e          prev_cls;
    ratio_e          ratio_q;
    logic [REC_W-1:0] rec_cnt;

    ratio_e      cls;
    int unsigned nom;
    int unsigned len;
    int unsigned dev;
    logic        jump_bad;
    logic        edge_late;

    always_comb begin
        len       = 32'(count);
        cls       = classify(len, 32'(TOL));
        nom       = nominal_len(ratio_q);
        dev       = (len >= nom) ? (len - nom) : (nom - len);
        jump_bad  = beyond_limit(dev, nom, 32'(bpf), 32'(SHIFT_BCK));
        edge_late = (len > nom) &&
                    beyond_limit(len - nom, nom, 32'(bpf), 32'(SHIFT_BCK));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_ACQUIRE;
            prev_cls <= RATIO_NONE;
            ratio_q  <= RATIO_NONE;
            rec_cnt  <= '0;
        end else begin
            case (st)
                ST_ACQUIRE: begin
                    if (edge_ok) begin
                        prev_cls <= cls;
                        if (cls != RATIO_NONE && cls == prev_cls) begin
                            st      <= ST_LOCKED;
                            ratio_q <= cls;
                            rec_cnt <= '0;
                        end
                    end
                end
                default: begin
                    if (edge_ok) begin
                        if (jump_bad) begin
                            st       <= ST_ACQUIRE;
                            prev_cls <= RATIO_NONE;
                            rec_cnt  <= '0;
                        end else if (rec_cnt != REC_DONE) begin
                            rec_cnt <= rec_cnt + 1'b1;
                        end
                    end else if (edge_late) begin
                        st       <= ST_ACQUIRE;
                        prev_cls <= RATIO_NONE;
                        rec_cnt  <= '0;
                    end
                end
            endcase
        end
    end

    assign mon.locked  = (st == ST_LOCKED);
    assign mon.running = (st == ST_LOCKED) && (rec_cnt == REC_DONE);
    assign mon.ratio   = ratio_q;
endmodule

// File: rtl/clkmon_ce_gen.sv
module clkmon_ce_gen
    import clkmon_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  ratio_e ratio,
    output logic   ce
);
    logic [1:0] phase;
    logic [1:0] wrap;

    always_comb begin
        case (ratio)
            RATIO_384: wrap = 2'd2;
            RATIO_512: wrap = 2'd1;
            default:   wrap = 2'd0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)               phase <= '0;
        else if (phase >= wrap) phase <= '0;
        else                   phase <= phase + 1'b1;
    end

    always_comb begin
        case (ratio)
            RATIO_256: ce = 1'b1;
            RATIO_384: ce = (phase != 2'd2);
            RATIO_512: ce = (phase == 2'd0);
            default:   ce = 1'b0;
        endcase
    end
endmodule

// File: rtl/clk_ratio_monitor.sv
module clk_ratio_monitor
    import clkmon_pkg::*;
#(
    parameter int CNT_W          = 12,
    parameter int BPF_W          = 8,
    parameter int TOL            = 2,
    parameter int SHIFT_BCK      = 4,
    parameter int RECOVER_FRAMES = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lrck,
    input  logic [BPF_W-1:0] bck_per_frame,
    output logic [1:0]       ratio,
    output logic             ce_256fs,
    output logic             sync_ok,
    output logic             adc_zero,
    output logic             dac_hold
);
    logic             edge_ok;
    logic [CNT_W-1:0] count;
    mon_state_t       mon;

    clkmon_frame_meter #(.CNT_W(CNT_W)) u_meter (
        .clk     (clk),
        .rst     (rst),
        .lrck    (lrck),
        .edge_ok (edge_ok),
        .count   (count)
    );

    clkmon_sync_fsm #(
        .CNT_W          (CNT_W),
        .BPF_W          (BPF_W),
        .TOL            (TOL),
        .SHIFT_BCK      (SHIFT_BCK),
        .RECOVER_FRAMES (RECOVER_FRAMES)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .edge_ok (edge_ok),
        .count   (count),
        .bpf     (bck_per_frame),
        .mon     (mon)
    );

    clkmon_ce_gen u_ce (
        .clk   (clk),
        .rst   (rst),
        .ratio (mon.ratio),
        .ce    (ce_256fs)
    );

    assign ratio    = mon.ratio;
    assign sync_ok  = mon.locked;
    assign adc_zero = ~mon.running;
    assign dac_hold = ~mon.running;
endmodule

// File: rtl/clk_ratio_monitor_chk.sv
module clk_ratio_monitor_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] ratio,
    input logic       ce_256fs,
    input logic       sync_ok,
    input logic       adc_zero,
    input logic       dac_hold
);
    assert_unsync_mutes_R8: assert property (@(posedge clk) disable iff (rst)
        !sync_ok |-> (adc_zero && dac_hold));

    assert_no_ce_without_ratio_R5: assert property (@(posedge clk) disable iff (rst)
        (ratio == 2'd0) |-> !ce_256fs);

    assert_384_two_of_three_R4: assert property (@(posedge clk) disable iff (rst)
        (ratio == 2'd2 && $past(ratio) == 2'd2 && $past(ratio, 2) == 2'd2) |->
        ($countones({ce_256fs, $past(ce_256fs), $past(ce_256fs, 2)}) == 2));

    assert_512_alternates_R4: assert property (@(posedge clk) disable iff (rst)
        (ratio == 2'd3 && $past(ratio) == 2'd3) |-> (ce_256fs != $past(ce_256fs)));

    assert_ratio_moves_on_lock_R3: assert property (@(posedge clk) disable iff (rst)
        (ratio != $past(ratio)) |-> $rose(sync_ok));

    assert_lock_has_ratio_R3: assert property (@(posedge clk) disable iff (rst)
        sync_ok |-> (ratio != 2'd0));

    assert_release_while_locked_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(adc_zero) |-> sync_ok);
endmodule

bind clk_ratio_monitor clk_ratio_monitor_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .ratio    (ratio),
    .ce_256fs (ce_256fs),
    .sync_ok  (sync_ok),
    .adc_zero (adc_zero),
    .dac_hold (dac_hold)
);

// File: tb/tb_clk_ratio_monitor.sv
module tb_clk_ratio_monitor;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       lrck = 1'b0;
    logic [7:0] bck = 8'd64;
    logic [1:0] ratio;
    logic       ce_256fs, sync_ok, adc_zero, dac_hold;

    int  checks = 0;
    int  errors = 0;
    int  flen = 256;
    int  extra = 0;
    bit  lrck_run = 1'b0;

    always #2.5 clk = ~clk;

    clk_ratio_monitor dut (
        .clk(clk), .rst(rst), .lrck(lrck), .bck_per_frame(bck),
        .ratio(ratio), .ce_256fs(ce_256fs), .sync_ok(sync_ok),
        .adc_zero(adc_zero), .dac_hold(dac_hold)
    );

    // Frame clock source: one frame of flen+extra cycles, extra is one-shot.
    initial begin
        forever begin
            if (!lrck_run) begin
                lrck = 1'b0;
                @(negedge clk);
            end else begin
                int n;
                n = flen + extra;
                extra = 0;
                lrck = 1'b1;
                repeat (n / 2) @(negedge clk);
                lrck = 1'b0;
                repeat (n - n / 2) @(negedge clk);
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input string what, input int act, input int exp);
        check(act == exp, req, what, act, exp);
    endtask

    task automatic do_reset();
        lrck_run = 1'b0;
        repeat (1200) @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic start_run(input int len, input int bpf);
        do_reset();
        flen = len;
        bck = 8'(bpf);
        lrck_run = 1'b1;
    endtask

    task automatic wait_rises(input int k);
        repeat (k) begin
            @(posedge lrck);
            @(negedge clk);
        end
    endtask

    task automatic count_ce(input int cycles, output int n);
        n = 0;
        repeat (cycles) begin
            @(negedge clk);
            if (ce_256fs) n++;
        end
    endtask

    task automatic t_reset();
        lrck_run = 1'b0;
        rst = 1'b1;
        repeat (4) @(negedge clk);
        chk_eq("R1", "ratio in reset", int'(ratio), 0);
        chk_eq("R1", "ce in reset", int'(ce_256fs), 0);
        chk_eq("R1", "sync_ok in reset", int'(sync_ok), 0);
        chk_eq("R1", "adc_zero in reset", int'(adc_zero), 1);
        chk_eq("R1", "dac_hold in reset", int'(dac_hold), 1);
        rst = 1'b0;
        @(negedge clk);
        chk_eq("R1", "sync_ok after reset", int'(sync_ok), 0);
    endtask

    task automatic t_lock_256();
        int n;
        start_run(256, 64);
        wait_rises(2);
        chk_eq("R3", "no lock after one period", int'(sync_ok), 0);
        chk_eq("R5", "ce with no ratio", int'(ce_256fs), 0);
        wait_rises(1);
        chk_eq("R3", "lock on third edge", int'(sync_ok), 1);
        chk_eq("R2", "ratio code 256x", int'(ratio), 1);
        chk_eq("R9", "adc_zero right after lock", int'(adc_zero), 1);
        wait_rises(31);
        chk_eq("R9", "adc_zero at 31st edge", int'(adc_zero), 1);
        chk_eq("R9", "dac_hold at 31st edge", int'(dac_hold), 1);
        wait_rises(1);
        chk_eq("R9", "adc_zero at 32nd edge", int'(adc_zero), 0);
        chk_eq("R9", "dac_hold at 32nd edge", int'(dac_hold), 0);
        count_ce(96, n);
        chk_eq("R4", "ce count 256x over 96", n, 96);
        // R6: +16 cycles is exactly the limit for N=256, 64 BCK
        extra = 16;
        wait_rises(3);
        chk_eq("R6", "shift 16 ignored sync", int'(sync_ok), 1);
        chk_eq("R6", "shift 16 ignored adc_zero", int'(adc_zero), 0);
        wait_rises(1);
        extra = -17;
        wait_rises(1);
        chk_eq("R6", "sync kept before bad frame ends", int'(sync_ok), 1);
        wait_rises(1);
        chk_eq("R6", "shift -17 loses sync", int'(sync_ok), 0);
        chk_eq("R8", "adc_zero while unsynced", int'(adc_zero), 1);
        chk_eq("R8", "dac_hold while unsynced", int'(dac_hold), 1);
        chk_eq("R8", "ratio held while unsynced", int'(ratio), 1);
        wait_rises(1);
        chk_eq("R10", "one fresh period not enough", int'(sync_ok), 0);
        wait_rises(1);
        chk_eq("R10", "relock after two periods", int'(sync_ok), 1);
    endtask

    task automatic t_ratio_384();
        int n;
        start_run(384, 48);
        wait_rises(3);
        chk_eq("R2", "ratio code 384x", int'(ratio), 2);
        count_ce(96, n);
        chk_eq("R4", "ce count 384x over 96", n, 64);
    endtask

    task automatic t_ratio_512();
        int n;
        start_run(512, 32);
        wait_rises(3);
        chk_eq("R2", "ratio code 512x", int'(ratio), 3);
        count_ce(96, n);
        chk_eq("R4", "ce count 512x over 96", n, 48);
        wait_rises(32);
        chk_eq("R9", "running at 512x", int'(adc_zero), 0);
        // R6: limit is 64 cycles for N=512, 32 BCK
        extra = -64;
        wait_rises(3);
        chk_eq("R6", "shift -64 ignored", int'(sync_ok), 1);
        chk_eq("R6", "shift -64 keeps running", int'(dac_hold), 0);
        extra = 65;
        wait_rises(2);
        chk_eq("R6", "shift +65 loses sync", int'(sync_ok), 0);
        chk_eq("R8", "ratio 512x held", int'(ratio), 3);
    endtask

    task automatic t_stopped_lrck();
        start_run(256, 64);
        wait_rises(36);
        chk_eq("R9", "running before stop", int'(adc_zero), 0);
        @(posedge lrck);
        lrck_run = 1'b0;
        @(negedge lrck);
        repeat (140) @(negedge clk);
        chk_eq("R7", "still locked before limit", int'(sync_ok), 1);
        repeat (10) @(negedge clk);
        chk_eq("R7", "lost with no edge", int'(sync_ok), 0);
        chk_eq("R8", "ratio held after timeout", int'(ratio), 1);
        chk_eq("R8", "adc_zero after timeout", int'(adc_zero), 1);
        flen = 512;
        bck = 8'd64;
        lrck_run = 1'b1;
        wait_rises(2);
        chk_eq("R10", "no lock yet at new rate", int'(sync_ok), 0);
        wait_rises(1);
        chk_eq("R10", "relock at new rate", int'(sync_ok), 1);
        chk_eq("R10", "new ratio 512x", int'(ratio), 3);
    endtask

    task automatic t_classify_edges();
        int n;
        start_run(258, 64);
        wait_rises(3);
        chk_eq("R2", "258 locks as 256x", int'(ratio), 1);
        start_run(259, 64);
        wait_rises(5);
        chk_eq("R2", "259 not accepted", int'(sync_ok), 0);
        start_run(382, 48);
        wait_rises(3);
        chk_eq("R2", "382 locks as 384x", int'(ratio), 2);
        start_run(300, 64);
        wait_rises(6);
        chk_eq("R2", "300 gives no ratio", int'(ratio), 0);
        chk_eq("R8", "adc_zero with no lock", int'(adc_zero), 1);
        count_ce(30, n);
        chk_eq("R5", "ce silent with no ratio", n, 0);
    endtask

    task automatic t_alternating();
        start_run(256, 64);
        repeat (7) begin
            @(posedge lrck);
            flen = (flen == 256) ? 384 : 256;
            @(negedge clk);
        end
        chk_eq("R3", "mixed classes never lock", int'(sync_ok), 0);
        chk_eq("R3", "mixed classes keep ratio none", int'(ratio), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_lock_256();
        t_ratio_384();
        t_ratio_512();
        t_stopped_lrck();
        t_classify_edges();
        t_alternating();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule